// File: doc/BRIEF.md
# Keyed configuration port

This block is a byte-wide configuration window for a legacy I/O space. It has two ports selected by one address bit: an index port (address bit 0) and a data port (address bit 1). The host first writes a register number to the index port, then reads or writes that register through the data port. All of this is refused until an entry key byte has been written to the index port twice in a row. A separate exit key locks the window again.

Once unlocked, the block serves a few global registers itself. These are a logical-device select, a read-only identification area (device ID, revision, vendor ID) and one enable bit for each logical device. Register numbers from 0x60 upward are not held here. They are passed to an attached block together with the selected device number, and that block's read byte is returned on the data port.

The host side uses plain strobes with no stall. A read strobe is answered one cycle later by `rvalid` and `rdata`, and there is no back-pressure. The attached bank must answer `dev_rdata` combinationally in the cycle of `dev_rd`.

Top module: `keyed_cfg_port`

## Requirements
- R1: The window unlocks only after two consecutive index-port writes of 0x87. Any other byte written to the index port while locked clears the progress. Data-port accesses while locked do not affect the progress.
- R2: While unlocked, an index-port write of 0xAA locks the window. The index register keeps its previous value across the exit and the next re-entry.
- R3: While locked, reads of either port return 0xFF, data-port writes change nothing, and `dev_wr` and `dev_rd` stay low.
- R4: While unlocked, an index-port write of any byte other than 0xAA loads the index register, and an index-port read returns it.
- R5: The identification registers are read-only:
  - 0x20 returns the device ID high byte and 0x21 its low byte.
  - 0x22 returns the revision.
  - 0x23 returns 0x19 and 0x24 returns 0x34.
- R6: Register 0x07 is the logical-device select. It is readable and writable and resets to 0x00.
- R7: Register 0x30 bit 0 is the enable of the selected device.
  - It drives `dev_enable[n]` and reads back as 0x00 or 0x01.
  - For a select of NUM_DEV or more, writes are ignored and reads return 0x00.
- R8: Data-port accesses at index 0x60 or above are forwarded to the attached bank.
  - Each write pulses `dev_wr` for one cycle, carrying `dev_num`=select, `dev_idx`=index and `dev_wdata`.
  - Each read pulses `dev_rd` and returns `dev_rdata`.
- R9: A data-port read at any other unimplemented index returns 0xFF, and a write there has no visible effect.
- R10: After reset, `rdata` is 0x00, `rvalid` is low and all enables are clear. Each read strobe gives `rvalid` high in the next cycle, with the read byte on `rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe |
| addr | input | 1 | 0 = index port, 1 = data port |
| wdata | input | 8 | Host write byte |
| rdata | output | 8 | Read result, valid with rvalid |
| rvalid | output | 1 | Read result strobe, one cycle after rd_en |
| dev_enable | output | NUM_DEV | Per-device enable bits |
| dev_wr | output | 1 | Forwarded bank write strobe |
| dev_rd | output | 1 | Forwarded bank read strobe |
| dev_num | output | 8 | Selected logical device |
| dev_idx | output | 8 | Register number inside the bank |
| dev_wdata | output | 8 | Forwarded write byte |
| dev_rdata | input | 8 | Bank read byte, same cycle as dev_rd |

## Verification
The bench builds the block with NUM_DEV=4, DEVICE_ID=0xC3A5 and REVISION=0x07. With only four devices, a select of 9 falls outside the enable vector, so the out-of-range enable path can be tested. The unusual ID values make a swapped byte order in the identification area visible. The attached bank is modelled as a function of device number and index, so a wrong `dev_num` or `dev_idx` shows up in the returned byte.

// File: rtl/kcp_pkg.sv
package kcp_pkg;
  localparam logic [7:0]  REG_LDSEL    = 8'h07;
  localparam logic [7:0]  REG_DEVID_HI = 8'h20;
  localparam logic [7:0]  REG_DEVID_LO = 8'h21;
  localparam logic [7:0]  REG_REV      = 8'h22;
  localparam logic [7:0]  REG_VEND_HI  = 8'h23;
  localparam logic [7:0]  REG_VEND_LO  = 8'h24;
  localparam logic [7:0]  REG_ENABLE   = 8'h30;
  localparam logic [7:0]  BANK_BASE    = 8'h60;
  localparam logic [15:0] VENDOR_ID    = 16'h1934;
  localparam logic [7:0]  IDLE_BYTE    = 8'hFF;

  typedef enum logic [1:0] {
    LK_SHUT = 2'd0,
    LK_HALF = 2'd1,
    LK_OPEN = 2'd2
  } lock_state_e;
endpackage

// File: rtl/kcp_key_unit.sv
module kcp_key_unit
  import kcp_pkg::*;
#(
  parameter logic [7:0] ENTER_KEY = 8'h87,
  parameter logic [7:0] EXIT_KEY  = 8'hAA
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idx_wr,
  input  logic [7:0] wdata,
  output logic       unlocked
);
  lock_state_e st_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= LK_SHUT;
    end else if (idx_wr) begin
      case (st_q)
        LK_SHUT: st_q <= (wdata == ENTER_KEY) ? LK_HALF : LK_SHUT;
        LK_HALF: st_q <= (wdata == ENTER_KEY) ? LK_OPEN : LK_SHUT;
        LK_OPEN: st_q <= (wdata == EXIT_KEY)  ? LK_SHUT : LK_OPEN;
        default: st_q <= LK_SHUT;
      endcase
    end
  end

  assign unlocked = (st_q == LK_OPEN);

  // R1
  entry_needs_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked) |-> $past(idx_wr && wdata == ENTER_KEY));
  // R2
  exit_relocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unlocked && idx_wr && wdata == EXIT_KEY |=> !unlocked);
endmodule

// File: rtl/kcp_regs.sv
module kcp_regs
  import kcp_pkg::*;
#(
  parameter int         NUM_DEV  = 8,
  parameter logic [7:0] EXIT_KEY = 8'hAA
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               unlocked,
  input  logic               idx_wr,
  input  logic               dat_wr,
  input  logic               dat_rd,
  input  logic [7:0]         wdata,
  output logic [7:0]         index_q,
  output logic [7:0]         ldsel_q,
  output logic [NUM_DEV-1:0] en_q,
  output logic               fwd_wr,
  output logic               fwd_rd
);
  logic in_bank;

  assign in_bank = (index_q >= BANK_BASE);
  assign fwd_wr  = unlocked && dat_wr && in_bank;
  assign fwd_rd  = unlocked && dat_rd && in_bank;

  always_ff @(posedge clk) begin
    if (!rst_n)                                      index_q <= 8'h00;
    else if (unlocked && idx_wr && wdata != EXIT_KEY) index_q <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                                         ldsel_q <= 8'h00;
    else if (unlocked && dat_wr && index_q == REG_LDSEL) ldsel_q <= wdata;
  end

  for (genvar g = 0; g < NUM_DEV; g++) begin : g_en
    always_ff @(posedge clk) begin
      if (!rst_n)
        en_q[g] <= 1'b0;
      else if (unlocked && dat_wr && index_q == REG_ENABLE && ldsel_q == 8'(g))
        en_q[g] <= wdata[0];
    end
  end

  // R2
  index_held_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked |=> $stable(index_q));
  // R7
  enables_held_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked |=> $stable(en_q));
  // R6
  ldsel_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unlocked && dat_wr && index_q == REG_LDSEL |=> ldsel_q == $past(wdata));
endmodule

// File: rtl/kcp_rdmux.sv
module kcp_rdmux
  import kcp_pkg::*;
#(
  parameter int          NUM_DEV   = 8,
  parameter logic [15:0] DEVICE_ID = 16'h4C21,
  parameter logic [7:0]  REVISION  = 8'h01
) (
  input  logic               unlocked,
  input  logic               port_sel,
  input  logic [7:0]         index_q,
  input  logic [7:0]         ldsel_q,
  input  logic [NUM_DEV-1:0] en_q,
  input  logic [7:0]         dev_rdata,
  output logic [7:0]         rd_byte
);
  logic sel_en;

  always_comb begin
    sel_en = 1'b0;
    for (int i = 0; i < NUM_DEV; i++)
      if (ldsel_q == 8'(i)) sel_en = en_q[i];
  end

  always_comb begin
    if (!unlocked)                 rd_byte = IDLE_BYTE;
    else if (!port_sel)            rd_byte = index_q;
    else if (index_q >= BANK_BASE) rd_byte = dev_rdata;
    else begin
      case (index_q)
        REG_LDSEL:    rd_byte = ldsel_q;
        REG_DEVID_HI: rd_byte = DEVICE_ID[15:8];
        REG_DEVID_LO: rd_byte = DEVICE_ID[7:0];
        REG_REV:      rd_byte = REVISION;
        REG_VEND_HI:  rd_byte = VENDOR_ID[15:8];
        REG_VEND_LO:  rd_byte = VENDOR_ID[7:0];
        REG_ENABLE:   rd_byte = {7'b0, sel_en};
        default:      rd_byte = IDLE_BYTE;
      endcase
    end
  end
endmodule

// File: rtl/keyed_cfg_port.sv
module keyed_cfg_port
  import kcp_pkg::*;
#(
  parameter int          NUM_DEV   = 8,
  parameter logic [15:0] DEVICE_ID = 16'h4C21,
  parameter logic [7:0]  REVISION  = 8'h01,
  parameter logic [7:0]  ENTER_KEY = 8'h87,
  parameter logic [7:0]  EXIT_KEY  = 8'hAA
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic               addr,
  input  logic [7:0]         wdata,
  output logic [7:0]         rdata,
  output logic               rvalid,
  output logic [NUM_DEV-1:0] dev_enable,
  output logic               dev_wr,
  output logic               dev_rd,
  output logic [7:0]         dev_num,
  output logic [7:0]         dev_idx,
  output logic [7:0]         dev_wdata,
  input  logic [7:0]         dev_rdata
);
  logic       unlocked, idx_wr, dat_wr, dat_rd;
  logic [7:0] index_q, ldsel_q, rd_byte;

  assign idx_wr = wr_en && !addr;
  assign dat_wr = wr_en && addr;
  assign dat_rd = rd_en && addr;

  kcp_key_unit #(.ENTER_KEY(ENTER_KEY), .EXIT_KEY(EXIT_KEY)) u_key (
    .clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .wdata(wdata), .unlocked(unlocked));

  kcp_regs #(.NUM_DEV(NUM_DEV), .EXIT_KEY(EXIT_KEY)) u_regs (
    .clk(clk), .rst_n(rst_n), .unlocked(unlocked), .idx_wr(idx_wr),
    .dat_wr(dat_wr), .dat_rd(dat_rd), .wdata(wdata), .index_q(index_q),
    .ldsel_q(ldsel_q), .en_q(dev_enable), .fwd_wr(dev_wr), .fwd_rd(dev_rd));

  kcp_rdmux #(.NUM_DEV(NUM_DEV), .DEVICE_ID(DEVICE_ID), .REVISION(REVISION)) u_mux (
    .unlocked(unlocked), .port_sel(addr), .index_q(index_q), .ldsel_q(ldsel_q),
    .en_q(dev_enable), .dev_rdata(dev_rdata), .rd_byte(rd_byte));

  assign dev_num   = ldsel_q;
  assign dev_idx   = index_q;
  assign dev_wdata = wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata  <= 8'h00;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd_en;
      if (rd_en) rdata <= rd_byte;
    end
  end

  // R10
  read_answered_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rvalid);
  // R10
  no_stray_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rvalid);
endmodule

// File: tb/tb_keyed_cfg_port.sv
module tb_keyed_cfg_port;
  localparam int ND = 4;

  logic clk = 1'b0;
  logic rst_n, wr_en, rd_en, addr;
  logic [7:0] wdata, rdata, dev_num, dev_idx, dev_wdata, dev_rdata;
  logic rvalid, dev_wr, dev_rd;
  logic [ND-1:0] dev_enable;

  always #2.5 clk = ~clk;

  keyed_cfg_port #(.NUM_DEV(ND), .DEVICE_ID(16'hC3A5), .REVISION(8'h07)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rvalid(rvalid), .dev_enable(dev_enable),
    .dev_wr(dev_wr), .dev_rd(dev_rd), .dev_num(dev_num), .dev_idx(dev_idx),
    .dev_wdata(dev_wdata), .dev_rdata(dev_rdata));

  // attached bank model
  assign dev_rdata = {dev_num[3:0], dev_idx[3:0]} ^ 8'hA5;

  function automatic logic [7:0] bank_val(input logic [7:0] n, input logic [7:0] i);
    return {n[3:0], i[3:0]} ^ 8'hA5;
  endfunction

  int nchk = 0, nerr = 0, wr_seen = 0, rd_seen = 0;
  logic [7:0] last_num, last_idx, last_dat;

  always @(posedge clk) begin
    if (dev_wr) begin
      wr_seen  <= wr_seen + 1;
      last_num <= dev_num;
      last_idx <= dev_idx;
      last_dat <= dev_wdata;
    end
    if (dev_rd) rd_seen <= rd_seen + 1;
  end

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } item_t;
  item_t sb[$];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && rvalid) begin
      if (sb.size() == 0) chk(1'b0, "R10 unexpected rvalid", 32'(rdata), 32'h0);
      else begin
        item_t it;
        it = sb.pop_front();
        chk(rdata === it.exp, it.tag, 32'(rdata), 32'(it.exp));
      end
    end
  end

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic a, input logic [7:0] exp, input string tag);
    @(negedge clk); rd_en = 1'b1; addr = a; sb.push_back('{exp, tag});
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog expired", 32'h0, 32'h1);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = 1'b0; wdata = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rvalid == 1'b0 && rdata == 8'h00, "R10 reset outputs", {23'b0, rvalid, rdata}, 32'h0);
    chk(dev_enable == '0, "R10 reset enables", 32'(dev_enable), 32'h0);

    // R3 locked reads
    rd(1'b1, 8'hFF, "R3 locked data read");
    rd(1'b0, 8'hFF, "R3 locked index read");

    // R1 key split by a data access still unlocks
    wr(1'b0, 8'h87);
    rd(1'b1, 8'hFF, "R1 half key still locked");
    wr(1'b0, 8'h87);
    rd(1'b0, 8'h00, "R1 unlocked, R4 index reset 00");
    wr(1'b0, 8'hAA);
    rd(1'b0, 8'hFF, "R2 relocked");

    // R1 broken sequence
    wr(1'b0, 8'h87); wr(1'b0, 8'h55); wr(1'b0, 8'h87);
    rd(1'b0, 8'hFF, "R1 broken sequence stays locked");
    wr(1'b0, 8'h87);
    rd(1'b0, 8'h00, "R1 second consecutive key unlocks");

    // R4 / R5
    wr(1'b0, 8'h22);
    rd(1'b0, 8'h22, "R4 index readback");
    rd(1'b1, 8'h07, "R5 revision");
    wr(1'b0, 8'h20); rd(1'b1, 8'hC3, "R5 device id high");
    wr(1'b0, 8'h21); rd(1'b1, 8'hA5, "R5 device id low");
    wr(1'b0, 8'h23); rd(1'b1, 8'h19, "R5 vendor high");
    wr(1'b0, 8'h24); wr(1'b1, 8'h00); rd(1'b1, 8'h34, "R5 vendor low read-only");

    // R6
    wr(1'b0, 8'h07); rd(1'b1, 8'h00, "R6 select reset");
    wr(1'b1, 8'h02); rd(1'b1, 8'h02, "R6 select readback");

    // R7
    wr(1'b0, 8'h30); wr(1'b1, 8'h01);
    rd(1'b1, 8'h01, "R7 enable readback");
    chk(dev_enable == 4'b0100, "R7 enable pin", 32'(dev_enable), 32'h4);
    wr(1'b0, 8'h07); wr(1'b1, 8'h03); wr(1'b0, 8'h30);
    rd(1'b1, 8'h00, "R7 other device clear");
    wr(1'b0, 8'h07); wr(1'b1, 8'h09); wr(1'b0, 8'h30); wr(1'b1, 8'h01);
    chk(dev_enable == 4'b0100, "R7 out-of-range write ignored", 32'(dev_enable), 32'h4);
    rd(1'b1, 8'h00, "R7 out-of-range read");

    // R8 forwarding
    wr(1'b0, 8'h07); wr(1'b1, 8'h02);
    chk(wr_seen == 0, "R8 no forward below bank", wr_seen, 0);
    wr(1'b0, 8'h61); wr(1'b1, 8'h3C);
    chk(wr_seen == 1, "R8 one forwarded write", wr_seen, 1);
    chk({last_num, last_idx, last_dat} == {8'h02, 8'h61, 8'h3C}, "R8 forwarded fields",
        {8'h0, last_num, last_idx, last_dat}, 32'h0002613C);
    rd(1'b1, bank_val(8'h02, 8'h61), "R8 bank read");
    chk(rd_seen == 1, "R8 one forwarded read", rd_seen, 1);
    wr(1'b0, 8'hFF); rd(1'b1, bank_val(8'h02, 8'hFF), "R8 top index");

    // R9 unimplemented
    wr(1'b0, 8'h5F); rd(1'b1, 8'hFF, "R9 unimplemented 5F");
    wr(1'b1, 8'h11);
    chk(wr_seen == 1, "R9 write not forwarded", wr_seen, 1);
    wr(1'b0, 8'h31); rd(1'b1, 8'hFF, "R9 unimplemented 31");

    // R2 / R3 exit behaviour
    wr(1'b0, 8'h70); wr(1'b0, 8'hAA);
    rd(1'b1, 8'hFF, "R2 data read after exit");
    wr(1'b1, 8'h55);
    chk(wr_seen == 1, "R3 locked write not forwarded", wr_seen, 1);
    wr(1'b0, 8'h87); wr(1'b0, 8'h87);
    rd(1'b0, 8'h70, "R2 index kept over exit");
    rd(1'b1, bank_val(8'h02, 8'h70), "R2 select kept, bank read");
    wr(1'b0, 8'h30); wr(1'b0, 8'hAA); wr(1'b1, 8'h00);
    chk(dev_enable == 4'b0100, "R2 locked enable write ignored", 32'(dev_enable), 32'h4);
    wr(1'b0, 8'h87); wr(1'b0, 8'h87);
    rd(1'b1, 8'h01, "R2 enable unchanged after re-entry");

    repeat (3) @(negedge clk);
    chk(sb.size() == 0, "R10 all reads answered", sb.size(), 0);
    finish_run();
  end
endmodule